// File: doc/BRIEF.md
# Time-of-Day Register Front End

This block sits between a simple single-cycle register bus and a free-running time-of-day counter that keeps 48-bit seconds and 32-bit nanoseconds. It lets software read a coherent timestamp in three 32-bit accesses and set a new time atomically. Reading the nanoseconds word returns the live nanoseconds and, at the same clock edge, freezes the live seconds into a snapshot. The two seconds words that are read next come from that snapshot, so the counter can keep running between the accesses.

Setting the time works the other way round. The two seconds words are written first and only staged. Writing the nanoseconds word then issues a one-cycle load strobe to the counter, carrying the staged seconds and the new nanoseconds, which are clamped into the legal range. A read-only word reports the counter clock rate in Hz. Five further word offsets (period and adjustment controls of the counter) are decoded here and handed straight to the counter core through a small side port.

Top module: `tod_regfront`

## Requirements
- R1: A read of the nanoseconds word (offset 0x108) returns the live nanoseconds in the cycle after the read, raises `cap_o` during the read cycle and freezes the live seconds; later reads of the seconds words return the frozen value even if the live seconds change, and a seconds read before any capture returns the reset snapshot of zero.
- R2: Seconds are split across two words: the low word (offset 0x104) holds seconds bits 31:0 and the high word (offset 0x100) holds seconds bits 47:32 in its bits 15:0.
- R3: Writes to the seconds words do not raise `load_o`; a write of the nanoseconds word raises `load_o` for exactly the following cycle, with `load_sec_o` equal to the staged high and low words.
- R4: On a nanoseconds write, `load_ns_o` equals the written value when it is below 1,000,000,000 and 999,999,999 otherwise.
- R5: Bits 31:16 of the seconds-high word read as zero, and bits 31:16 of a value written to it are ignored.
- R6: The word at offset 0x038 reads as the parameter `CLK_HZ`; writes to it have no effect on its value.
- R7: Staged seconds words are kept after a commit, so a second nanoseconds write without new seconds writes loads the same seconds; `load_sec_o` and `load_ns_o` stay constant while `load_o` is low.
- R8: When a read and a write of the nanoseconds word fall in the same cycle, the read returns the live nanoseconds from before the load and the load takes place as in R3.
- R9: The five words at offsets 0x110, 0x114, 0x118, 0x11C and 0x120 map to `aux_idx_o` 0 to 4: during an access `aux_wr_o` or `aux_rd_o` follows the bus strobe, `aux_wdata_o` carries the write data, and a read returns `aux_rdata_i` in the next cycle.
- R10: `reg_rdata` is zero in the cycle after an idle cycle or a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address of the accessed word |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| live_sec_i | input | 48 | Running seconds from the counter core |
| live_ns_i | input | 32 | Running nanoseconds from the counter core |
| cap_o | output | 1 | Capture indication, high during a nanoseconds read |
| load_o | output | 1 | One-cycle load strobe to the counter core |
| load_sec_o | output | 48 | Seconds to load |
| load_ns_o | output | 32 | Nanoseconds to load, clamped |
| aux_wr_o | output | 1 | Write strobe for a period or adjustment word |
| aux_rd_o | output | 1 | Read strobe for a period or adjustment word |
| aux_idx_o | output | 3 | Index of the period or adjustment word |
| aux_wdata_o | output | 32 | Write data for the period or adjustment word |
| aux_rdata_i | input | 32 | Read data of the period or adjustment word |

## Verification
The capture of the live time and the commit of a new time both hang on the nanoseconds word, so they can land in the same cycle when a read and a write strobe of that offset are raised together. The bench provokes this with live values chosen to differ from the written time, and judges that the returned word is the old live nanoseconds while the load strobe and the clamped load value appear in the next cycle. It also changes the live seconds after each capture and before the seconds reads, so a snapshot that follows the counter instead of freezing shows up as a mismatch.

// File: rtl/tod_rf_pkg.sv
package tod_rf_pkg;

    parameter int unsigned ADDR_W = 12;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned SEC_W  = 48;
    parameter int unsigned NS_W   = 32;
    localparam int unsigned SECHI_W = SEC_W - DATA_W;

    parameter logic [ADDR_W-1:0] OFS_FREQ  = 12'h038;
    parameter logic [ADDR_W-1:0] OFS_SECHI = 12'h100;
    parameter logic [ADDR_W-1:0] OFS_SECLO = 12'h104;
    parameter logic [ADDR_W-1:0] OFS_NSEC  = 12'h108;
    parameter logic [ADDR_W-1:0] OFS_AUX0  = 12'h110;

    parameter int unsigned AUX_N  = 5;
    localparam int unsigned AUX_IW = $clog2(AUX_N);

    parameter logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

    // decoded access target
    typedef struct packed {
        logic              sechi;
        logic              seclo;
        logic              nsec;
        logic              freq;
        logic              aux;
        logic [AUX_IW-1:0] aux_idx;
    } sel_t;

    // staging and commit state
    typedef struct packed {
        logic [SECHI_W-1:0] hi;
        logic [DATA_W-1:0]  lo;
        logic               load;
        logic [SEC_W-1:0]   sec;
        logic [NS_W-1:0]    ns;
    } stage_t;

    // frozen seconds
    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } snap_t;

    // read data register
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    function automatic logic [NS_W-1:0] ns_clamp(input logic [NS_W-1:0] v);
        return (v >= NS_PER_SEC) ? (NS_PER_SEC - NS_W'(1)) : v;
    endfunction

endpackage

// File: rtl/tod_rf_decode.sv
module tod_rf_decode
    import tod_rf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output sel_t              sel_o
);

    logic [AUX_N-1:0] aux_hit;

    genvar g;
    generate
        for (g = 0; g < AUX_N; g++) begin : g_aux
            assign aux_hit[g] = (addr_i == (OFS_AUX0 + ADDR_W'(4 * g)));
        end
    endgenerate

    always_comb begin
        sel_o       = '0;
        sel_o.sechi = (addr_i == OFS_SECHI);
        sel_o.seclo = (addr_i == OFS_SECLO);
        sel_o.nsec  = (addr_i == OFS_NSEC);
        sel_o.freq  = (addr_i == OFS_FREQ);
        sel_o.aux   = |aux_hit;
        for (int i = 0; i < AUX_N; i++) begin
            if (aux_hit[i]) begin
                sel_o.aux_idx = AUX_IW'(i);
            end
        end
    end

endmodule

// File: rtl/tod_rf_stage.sv
module tod_rf_stage
    import tod_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sel_t              sel_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              load_o,
    output logic [SEC_W-1:0]  load_sec_o,
    output logic [NS_W-1:0]   load_ns_o
);

    stage_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (wr_i && sel_i.sechi) begin
            st_d.hi = wdata_i[SECHI_W-1:0];
        end
        if (wr_i && sel_i.seclo) begin
            st_d.lo = wdata_i;
        end
        if (wr_i && sel_i.nsec) begin
            st_d.load = 1'b1;
            st_d.sec  = {st_q.hi, st_q.lo};
            st_d.ns   = ns_clamp(NS_W'(wdata_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o     = st_q.load;
    assign load_sec_o = st_q.sec;
    assign load_ns_o  = st_q.ns;

endmodule

// File: rtl/tod_rf_snap.sv
module tod_rf_snap
    import tod_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [SEC_W-1:0] live_sec_i,
    output logic [SEC_W-1:0] snap_sec_o
);

    snap_t sn_d, sn_q;

    always_comb begin
        sn_d = sn_q;
        if (cap_i) begin
            sn_d.sec = live_sec_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sn_q <= '0;
        end else begin
            sn_q <= sn_d;
        end
    end

    assign snap_sec_o = sn_q.sec;

endmodule

// File: rtl/tod_regfront.sv
module tod_regfront
    import tod_rf_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [SEC_W-1:0]    live_sec_i,
    input  logic [NS_W-1:0]     live_ns_i,
    output logic                cap_o,
    output logic                load_o,
    output logic [SEC_W-1:0]    load_sec_o,
    output logic [NS_W-1:0]     load_ns_o,
    output logic                aux_wr_o,
    output logic                aux_rd_o,
    output logic [AUX_IW-1:0]   aux_idx_o,
    output logic [DATA_W-1:0]   aux_wdata_o,
    input  logic [DATA_W-1:0]   aux_rdata_i
);

    localparam logic [DATA_W-1:0] FREQ_WORD = DATA_W'(CLK_HZ);

    sel_t             sel;
    logic [SEC_W-1:0] snap_sec;
    rd_t              rd_d, rd_q;

    tod_rf_decode u_dec (
        .addr_i (reg_addr),
        .sel_o  (sel)
    );

    assign cap_o = reg_rd && sel.nsec;

    tod_rf_snap u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap_o),
        .live_sec_i (live_sec_i),
        .snap_sec_o (snap_sec)
    );

    tod_rf_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .wr_i       (reg_wr),
        .wdata_i    (reg_wdata),
        .load_o     (load_o),
        .load_sec_o (load_sec_o),
        .load_ns_o  (load_ns_o)
    );

    // pass-through of period and adjustment words
    assign aux_wr_o    = reg_wr && sel.aux;
    assign aux_rd_o    = reg_rd && sel.aux;
    assign aux_idx_o   = sel.aux_idx;
    assign aux_wdata_o = reg_wdata;

    always_comb begin
        rd_d.rdata = '0;
        if (reg_rd) begin
            if (sel.nsec) begin
                rd_d.rdata = DATA_W'(live_ns_i);
            end else if (sel.seclo) begin
                rd_d.rdata = snap_sec[DATA_W-1:0];
            end else if (sel.sechi) begin
                rd_d.rdata = {{(DATA_W-SECHI_W){1'b0}}, snap_sec[SEC_W-1:DATA_W]};
            end else if (sel.freq) begin
                rd_d.rdata = FREQ_WORD;
            end else if (sel.aux) begin
                rd_d.rdata = aux_rdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata = rd_q.rdata;

endmodule

// File: rtl/tod_regfront_chk.sv
module tod_regfront_chk
    import tod_rf_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NS_W-1:0]   live_ns_i,
    input logic              load_o,
    input logic [SEC_W-1:0]  load_sec_o,
    input logic [NS_W-1:0]   load_ns_o
);

    AST_NS_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == OFS_NSEC) |-> reg_rdata == DATA_W'($past(live_ns_i))); // R1

    AST_LOAD_FROM_NS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(reg_wr && reg_addr == OFS_NSEC)); // R3

    AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> load_ns_o < NS_PER_SEC); // R4

    AST_SECHI_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == OFS_SECHI) |-> reg_rdata[DATA_W-1:SECHI_W] == '0); // R5

    AST_FREQ_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == OFS_FREQ) |-> reg_rdata == DATA_W'(CLK_HZ)); // R6

    AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> ($stable(load_sec_o) && $stable(load_ns_o))); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!reg_rd) |-> reg_rdata == '0); // R10

endmodule

bind tod_regfront tod_regfront_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .live_ns_i  (live_ns_i),
    .load_o     (load_o),
    .load_sec_o (load_sec_o),
    .load_ns_o  (load_ns_o)
);

// File: tb/sim_tod_regfront.sv
`timescale 1ns/1ps
module sim_tod_regfront;

    localparam int unsigned HZ = 200_000_000;
    localparam logic [11:0] A_HI = 12'h100, A_LO = 12'h104, A_NS = 12'h108;
    localparam logic [11:0] A_FQ = 12'h038, A_AUX = 12'h110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [47:0] live_sec = '0;
    logic [31:0] live_ns = '0;
    logic        cap_o, load_o, aux_wr_o, aux_rd_o;
    logic [47:0] load_sec_o;
    logic [31:0] load_ns_o, aux_wdata_o;
    logic [2:0]  aux_idx_o;
    logic [31:0] aux_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tod_regfront #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .live_sec_i(live_sec), .live_ns_i(live_ns), .cap_o(cap_o),
        .load_o(load_o), .load_sec_o(load_sec_o), .load_ns_o(load_ns_o),
        .aux_wr_o(aux_wr_o), .aux_rd_o(aux_rd_o), .aux_idx_o(aux_idx_o),
        .aux_wdata_o(aux_wdata_o), .aux_rdata_i(aux_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] clampv(input logic [31:0] v);
        return (v >= 32'd1_000_000_000) ? 32'd999_999_999 : v;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R10 reset rdata", 64'(reg_rdata), 64'h0);
        chk("R3 reset load", 64'(load_o), 64'h0);
        chk("R7 reset load_sec", 64'(load_sec_o), 64'h0);
        rd(A_LO, v);
        chk("R1 seconds before capture", 64'(v), 64'h0);

        // sweep of set-time and snapshot reads
        for (int i = 0; i < 32; i++) begin
            logic [47:0] s;
            logic [31:0] n;
            s = 48'(i) * 48'h0123_4567_89AB + 48'h0000_0000_0007;
            n = 32'(i) * 32'd37_000_001;
            wr(A_HI, {16'hBEEF, s[47:32]});
            chk("R3 no load on hi write", 64'(load_o), 64'h0);
            wr(A_LO, s[31:0]);
            chk("R3 no load on lo write", 64'(load_o), 64'h0);
            wr(A_NS, n);
            chk("R3 load pulse", 64'(load_o), 64'h1);
            chk("R2 R5 load seconds", 64'(load_sec_o), 64'(s));
            chk("R4 load nanoseconds", 64'(load_ns_o), 64'(clampv(n)));
            @(negedge clk);
            chk("R3 pulse one cycle", 64'(load_o), 64'h0);
            chk("R7 load value held", 64'(load_sec_o), 64'(s));

            live_sec = ~s;
            live_ns = n ^ 32'h5A5A_0000;
            @(negedge clk);
            reg_addr = A_NS; reg_rd = 1'b1;
            #1 chk("R1 capture strobe", 64'(cap_o), 64'h1);
            @(negedge clk);
            reg_rd = 1'b0;
            chk("R1 nanoseconds live", 64'(reg_rdata), 64'(n ^ 32'h5A5A_0000));
            live_sec = s;
            rd(A_LO, v);
            chk("R1 R2 low snapshot", 64'(v), 64'((~s) & 48'h0000_FFFF_FFFF));
            rd(A_HI, v);
            chk("R1 R5 high snapshot", 64'(v), 64'({16'h0, (~s) >> 32}));
        end

        // clamp boundaries
        wr(A_NS, 32'd999_999_999);
        chk("R4 max legal", 64'(load_ns_o), 64'd999_999_999);
        wr(A_NS, 32'd1_000_000_000);
        chk("R4 first illegal", 64'(load_ns_o), 64'd999_999_999);
        wr(A_NS, 32'hFFFF_FFFF);
        chk("R4 all ones", 64'(load_ns_o), 64'd999_999_999);

        // staged seconds kept across commits
        wr(A_HI, 32'h0000_00AB);
        wr(A_LO, 32'h1234_5678);
        wr(A_NS, 32'd10);
        wr(A_NS, 32'd20);
        chk("R7 reload keeps seconds", 64'(load_sec_o), 64'h00AB_1234_5678);
        chk("R7 reload nanoseconds", 64'(load_ns_o), 64'd20);

        // frequency word
        rd(A_FQ, v);
        chk("R6 frequency", 64'(v), 64'(HZ));
        wr(A_FQ, 32'h1);
        rd(A_FQ, v);
        chk("R6 frequency after write", 64'(v), 64'(HZ));

        // read and write of nanoseconds in one cycle
        live_ns = 32'd777;
        live_sec = 48'h0000_0000_0042;
        @(negedge clk);
        reg_addr = A_NS; reg_rd = 1'b1; reg_wr = 1'b1; reg_wdata = 32'd1_500_000_000;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        chk("R8 read sees old live", 64'(reg_rdata), 64'd777);
        chk("R8 load strobe", 64'(load_o), 64'h1);
        chk("R8 load clamped", 64'(load_ns_o), 64'd999_999_999);
        rd(A_LO, v);
        chk("R8 snapshot seconds", 64'(v), 64'h42);

        // pass-through words
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            reg_addr = A_AUX + 12'(4 * k); reg_wr = 1'b1; reg_wdata = 32'hC0DE_0000 + 32'(k);
            #1;
            chk("R9 aux write strobe", 64'(aux_wr_o), 64'h1);
            chk("R9 aux index", 64'(aux_idx_o), 64'(k));
            chk("R9 aux wdata", 64'(aux_wdata_o), 64'(32'hC0DE_0000 + 32'(k)));
            @(negedge clk);
            reg_wr = 1'b0;
            chk("R9 no load from aux", 64'(load_o), 64'h0);
            aux_rdata = 32'h5EED_0000 + 32'(k);
            reg_rd = 1'b1;
            #1 chk("R9 aux read strobe", 64'(aux_rd_o), 64'h1);
            @(negedge clk);
            reg_rd = 1'b0;
            chk("R9 aux read data", 64'(reg_rdata), 64'(32'h5EED_0000 + 32'(k)));
        end

        // unmapped and idle
        rd(12'h10C, v);
        chk("R10 unmapped read", 64'(v), 64'h0);
        @(negedge clk);
        chk("R10 idle rdata", 64'(reg_rdata), 64'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule